// File: doc/BRIEF.md
# Pulse-Echo Acquisition Sequencer

This block runs one detection cycle of a pulse-reflection ultrasonic tester, clocked at the 40 MHz ADC sample rate. A host controller sends a periodic square wave on `trig_i`. Each rising edge that finds the block idle starts one cycle, which runs through a fixed series of phases. First an excitation pulse of programmable width is sent to the transmitter stage. Then the block waits a programmable hold-off while the wave crosses the couplant. Next it captures a programmable number of signed 8-bit ADC samples. Last, it opens a judgment window for the defect logic downstream, gives a one-cycle done flag and goes back to idle.

The capture has two modes, chosen by a plate-thickness bit. In thin-plate mode every sample is written to the buffer. In medium-thick mode the samples are compressed by a factor N before storage. Each group of N keeps the sample of largest magnitude, so echo peaks are kept. Width, delay, sample count, mode and factor are all sampled at the accepted trigger edge. A trigger edge that arrives during a cycle is dropped and sets a sticky overrun flag.

Top module: `pulse_echo_seq`

## Requirements
- R1: A rising edge on `trig_i` that is seen while the block is idle starts a cycle, and `excite_o` goes high in the next clock cycle.
- R2: `excite_o` stays high for exactly `cfg_width_i` cycles. A width of 0 acts as 1.
- R3: `smp_valid_o` rises exactly `cfg_delay_i` cycles after `excite_o` falls. A delay of 0 makes capture follow the pulse with no gap.
- R4: `smp_valid_o` stays high for exactly `cfg_count_i` cycles. A count of 0 acts as 1. One `adc_i` value is taken at the end of each of these cycles.
- R5: With `cfg_thick_i` = 0, every captured sample appears on `wr_data_o` with `wr_en_o` high, one cycle after it is taken, unchanged.
- R6: With `cfg_thick_i` = 1, the samples are split into consecutive groups of N. N is `cfg_decim_i`, with 0 acting as 1 and values above 16 acting as 16. One write per group carries the group's sample of largest two's-complement magnitude (-128 counts as 128), and on a tie the earliest such sample wins. A shorter last group is still written. Each write comes one cycle after the group's last sample.
- R7: Right after capture, `judge_en_o` is high for JUDGE_LEN cycles (default 8). Then `done_o` is high for one cycle, and the block is idle in the cycle after that.
- R8: A rising edge on `trig_i` seen at any point from the first excitation cycle through the done cycle is ignored. It sets `overrun_o`, which stays set until reset.
- R9: Configuration inputs changed after a cycle has started do not affect that cycle.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (40 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Periodic trigger from host; rising edge starts a cycle |
| cfg_width_i | input | 16 | Excitation width in clocks |
| cfg_delay_i | input | 16 | Couplant hold-off in clocks |
| cfg_count_i | input | 16 | Number of samples to capture |
| cfg_thick_i | input | 1 | 0 = store every sample, 1 = peak-keeping compression |
| cfg_decim_i | input | 5 | Compression factor N |
| adc_i | input | 8 | Signed ADC sample |
| excite_o | output | 1 | Low-voltage excitation pulse |
| smp_valid_o | output | 1 | High during the sampling window |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_data_o | output | 8 | Buffer write data |
| judge_en_o | output | 1 | Defect-judgment window |
| done_o | output | 1 | One-cycle end-of-cycle flag |
| overrun_o | output | 1 | Sticky flag for a dropped trigger |

## Verification
The assertions assume that the configuration inputs only matter at the accepted trigger edge, and that `trig_i` is a clean level in the clock domain, with no glitch between edges. The bench changes inputs only on falling clock edges. Every trigger is a level held for at least one full cycle. Configuration is changed in the middle of a cycle only on purpose, to show that the latched values are used. Sample values come from a random stream and from fixed patterns with ties and the two extreme codes, so the magnitude compare sees its corner values.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  localparam int SMP_W = 8;
  localparam int CNT_W = 16;
  localparam int DEC_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_EXCITE,
    PH_DELAY,
    PH_CAPTURE,
    PH_JUDGE,
    PH_DONE
  } phase_t;

  // A zero length is taken as one clock
  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // Magnitude of a two's-complement sample, one bit wider so -max fits
  function automatic logic [SMP_W:0] mag_of(input logic [SMP_W-1:0] s);
    logic [SMP_W:0] ext;
    ext = {s[SMP_W-1], s};
    return s[SMP_W-1] ? (~ext + 1'b1) : ext;
  endfunction

  // Compression factor limited to 1..top
  function automatic logic [DEC_W-1:0] clamp_decim(input logic [DEC_W-1:0] f,
                                                   input int unsigned top);
    if (f == '0) return DEC_W'(1);
    if (int'(f) > int'(top)) return DEC_W'(top);
    return f;
  endfunction

endpackage

// File: rtl/pe_trig_edge.sv
module pe_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);

  logic trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;

endmodule

// File: rtl/pe_phase_ctrl.sv
module pe_phase_ctrl
  import pe_seq_pkg::*;
#(
  parameter int CW        = CNT_W,
  parameter int FW        = DEC_W,
  parameter int JUDGE_LEN = 8,
  parameter int MAX_DECIM = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic [CW-1:0] cfg_width_i,
  input  logic [CW-1:0] cfg_delay_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          cfg_thick_i,
  input  logic [FW-1:0] cfg_decim_i,
  output phase_t        phase_o,
  output logic          start_o,
  output logic          take_o,
  output logic          last_o,
  output logic          mode_o,
  output logic [FW-1:0] decim_o,
  output logic          overrun_o
);

  localparam logic [CW-1:0] JUDGE_LOAD = CW'(JUDGE_LEN - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] delay_q;
  logic [CW-1:0] count_q;
  logic          mode_q;
  logic [FW-1:0] decim_q;
  logic          ovr_q;
  logic          cnt_zero;
  logic          busy_hit;

  assign cnt_zero = (cnt == '0);
  assign start_o  = rise_i && (phase == PH_IDLE);
  assign busy_hit = rise_i && (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      delay_q <= '0;
      count_q <= CW'(1);
      mode_q  <= 1'b0;
      decim_q <= FW'(1);
      ovr_q   <= 1'b0;
    end else begin
      if (busy_hit) ovr_q <= 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (rise_i) begin
            phase   <= PH_EXCITE;
            cnt     <= at_least_one(cfg_width_i) - 1'b1;
            delay_q <= cfg_delay_i;
            count_q <= at_least_one(cfg_count_i);
            mode_q  <= cfg_thick_i;
            decim_q <= clamp_decim(cfg_decim_i, MAX_DECIM);
          end
        end
        PH_EXCITE: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (delay_q == '0) begin
            phase <= PH_CAPTURE;
            cnt   <= count_q - 1'b1;
          end else begin
            phase <= PH_DELAY;
            cnt   <= delay_q - 1'b1;
          end
        end
        PH_DELAY: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else begin
            phase <= PH_CAPTURE;
            cnt   <= count_q - 1'b1;
          end
        end
        PH_CAPTURE: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else begin
            phase <= PH_JUDGE;
            cnt   <= JUDGE_LOAD;
          end
        end
        PH_JUDGE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else           phase <= PH_DONE;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase;
  assign take_o    = (phase == PH_CAPTURE);
  assign last_o    = (phase == PH_CAPTURE) && cnt_zero;
  assign mode_o    = mode_q;
  assign decim_o   = decim_q;
  assign overrun_o = ovr_q;

  // R1: an accepted edge always enters the excitation phase next
  a_r1_start_excite: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (phase == PH_EXCITE));

  // R8: overrun never clears outside reset
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R8: an edge during a busy cycle is flagged and does not restart it
  a_r8_busy_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> (overrun_o && (phase != PH_EXCITE || $past(phase) == PH_EXCITE)));

  // R4: capture ends into the judgment window
  a_r4_capture_to_judge: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (phase == PH_JUDGE));

  // R7: the done phase lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_IDLE));

  // R9: latched setup holds while a cycle runs
  a_r9_setup_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(count_q) && $stable(mode_q) && $stable(decim_q)));

endmodule

// File: rtl/pe_peak_decim.sv
module pe_peak_decim
  import pe_seq_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int FW = DEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          take_i,
  input  logic          last_i,
  input  logic          mode_i,
  input  logic [FW-1:0] decim_i,
  input  logic [SW-1:0] sample_i,
  output logic          wr_en_o,
  output logic [SW-1:0] wr_data_o
);

  logic [FW-1:0] grp;
  logic [SW-1:0] peak;
  logic [SW:0]   mag_new;
  logic [SW:0]   mag_old;
  logic          keep_new;
  logic [SW-1:0] cand;
  logic          grp_full;

  always_comb begin
    mag_new  = mag_of(sample_i);
    mag_old  = mag_of(peak);
    keep_new = (grp == '0) || (mag_new > mag_old);
    cand     = keep_new ? sample_i : peak;
    grp_full = ({1'b0, grp} + 1'b1) == {1'b0, decim_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp       <= '0;
      peak      <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        grp <= '0;
      end else if (take_i) begin
        if (!mode_i) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= sample_i;
        end else if (grp_full || last_i) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= cand;
          grp       <= '0;
        end else begin
          peak <= cand;
          grp  <= grp + 1'b1;
        end
      end
    end
  end

  // R6: the group position never reaches the factor
  a_r6_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mode_i) |-> (grp < decim_i));

  // R5: raw mode writes once for every sample taken
  a_r5_raw_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !mode_i) |=> wr_en_o);

  // R6: the final sample of a capture always flushes a write
  a_r6_last_flush: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> wr_en_o);

endmodule

// File: rtl/pulse_echo_seq.sv
module pulse_echo_seq
  import pe_seq_pkg::*;
#(
  parameter int JUDGE_LEN = 8,
  parameter int MAX_DECIM = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cfg_width_i,
  input  logic [CNT_W-1:0] cfg_delay_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             cfg_thick_i,
  input  logic [DEC_W-1:0] cfg_decim_i,
  input  logic [SMP_W-1:0] adc_i,
  output logic             excite_o,
  output logic             smp_valid_o,
  output logic             wr_en_o,
  output logic [SMP_W-1:0] wr_data_o,
  output logic             judge_en_o,
  output logic             done_o,
  output logic             overrun_o
);

  logic             rise;
  phase_t           phase;
  logic             start;
  logic             take;
  logic             last;
  logic             mode;
  logic [DEC_W-1:0] decim;

  pe_trig_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  pe_phase_ctrl #(
    .CW        (CNT_W),
    .FW        (DEC_W),
    .JUDGE_LEN (JUDGE_LEN),
    .MAX_DECIM (MAX_DECIM)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .cfg_width_i (cfg_width_i),
    .cfg_delay_i (cfg_delay_i),
    .cfg_count_i (cfg_count_i),
    .cfg_thick_i (cfg_thick_i),
    .cfg_decim_i (cfg_decim_i),
    .phase_o     (phase),
    .start_o     (start),
    .take_o      (take),
    .last_o      (last),
    .mode_o      (mode),
    .decim_o     (decim),
    .overrun_o   (overrun_o)
  );

  pe_peak_decim #(
    .SW (SMP_W),
    .FW (DEC_W)
  ) u_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .take_i    (take),
    .last_i    (last),
    .mode_i    (mode),
    .decim_i   (decim),
    .sample_i  (adc_i),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o)
  );

  assign excite_o    = (phase == PH_EXCITE);
  assign smp_valid_o = (phase == PH_CAPTURE);
  assign judge_en_o  = (phase == PH_JUDGE);
  assign done_o      = (phase == PH_DONE);

  // R7: a done flag is always preceded by the judgment window
  a_r7_judge_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(judge_en_o));

  // R3: sampling is never entered straight from idle
  a_r3_no_direct_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid_o) |-> !$past(phase == PH_IDLE));

endmodule

// File: tb/pulse_echo_seq_tb_top.sv
module pulse_echo_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int JUDGE_LEN  = 8;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] cfg_w = '0;
  logic [15:0] cfg_d = '0;
  logic [15:0] cfg_c = '0;
  logic        cfg_t = 1'b0;
  logic [4:0]  cfg_n = '0;
  logic [7:0]  adc = '0;
  logic        excite, svalid, wr_en, judge, done, ovr;
  logic [7:0]  wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_echo_seq #(.JUDGE_LEN(JUDGE_LEN), .MAX_DECIM(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig),
    .cfg_width_i(cfg_w), .cfg_delay_i(cfg_d), .cfg_count_i(cfg_c),
    .cfg_thick_i(cfg_t), .cfg_decim_i(cfg_n), .adc_i(adc),
    .excite_o(excite), .smp_valid_o(svalid), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .judge_en_o(judge), .done_o(done), .overrun_o(ovr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr_seen = 0;
  int pat = 0;
  int pat_i = 0;
  int cyc_all = 0;

  // Reference model: absolute cycle schedule of the current detection cycle
  int n = 0;
  int prev_trig = 0;
  int exc_s = -100, dly_s = -100, cap_s = -100, jud_s = -100, done_c = -100;
  int m_c = 1, m_nf = 1, m_thick = 0;
  int g = 0, pk = 0;
  int m_wr = 0, m_wd = 0, m_ovr = 0;
  int q_samples[$];

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, n);
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (!rst_n) begin
      n = 0; prev_trig = 0; m_wr = 0; m_ovr = 0; g = 0;
      exc_s = -100; dly_s = -100; cap_s = -100; jud_s = -100; done_c = -100;
    end else begin
      int s;
      int idx;
      int rise;
      n++;
      m_wr = 0;
      rise = (trig && !prev_trig) ? 1 : 0;
      prev_trig = trig;
      if (n - 1 >= cap_s && n - 1 < jud_s) begin
        idx = n - 1 - cap_s;
        s = int'($signed(adc));
        q_samples.push_back(s);
        if (!m_thick) begin
          m_wr = 1; m_wd = s;
        end else begin
          if (g == 0 || iabs(s) > iabs(pk)) pk = s;
          g++;
          if (g == m_nf || idx == m_c - 1) begin
            m_wr = 1; m_wd = pk; g = 0;
          end
        end
      end
      if (rise) begin
        if (n - 1 > done_c) begin
          int w;
          int d;
          w = (cfg_w == 0) ? 1 : int'(cfg_w);
          d = int'(cfg_d);
          m_c = (cfg_c == 0) ? 1 : int'(cfg_c);
          m_nf = (cfg_n == 0) ? 1 : ((cfg_n > 16) ? 16 : int'(cfg_n));
          m_thick = cfg_t;
          exc_s = n; dly_s = n + w; cap_s = n + w + d;
          jud_s = cap_s + m_c; done_c = jud_s + JUDGE_LEN;
          g = 0;
        end else begin
          m_ovr = 1;
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      if (wr_en) wr_seen++;
      tg = (n == exc_s) ? "R1" : "R2";
      chk(tg, "excite", int'(excite), int'(n >= exc_s && n < dly_s));
      tg = (n == cap_s) ? "R3" : "R4";
      chk(tg, "smp_valid", int'(svalid), int'(n >= cap_s && n < jud_s));
      tg = m_thick ? "R6" : "R5";
      chk(tg, "wr_en", int'(wr_en), m_wr);
      if (m_wr) chk(tg, "wr_data", int'($signed(wr_data)), m_wd);
      chk("R7", "judge_en", int'(judge), int'(n >= jud_s && n < done_c));
      chk("R7", "done", int'(done), int'(n == done_c));
      chk("R8", "overrun", int'(ovr), m_ovr);
    end
  end

  // ADC stimulus patterns
  always @(negedge clk) begin
    pat_i++;
    case (pat)
      1: adc <= (pat_i % 2) ? 8'sd3 : -8'sd3;
      2: case (pat_i % 5)
           0: adc <= 8'h80;
           1: adc <= 8'h7F;
           2: adc <= 8'h81;
           3: adc <= 8'h05;
           default: adc <= 8'hF0;
         endcase
      default: adc <= 8'($urandom);
    endcase
  end

  always @(posedge clk) begin
    if (cyc_all > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual hung expected cycle end");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic start_cycle(input int w, input int d, input int c, input int t, input int f);
    @(negedge clk);
    cfg_w = 16'(w); cfg_d = 16'(d); cfg_c = 16'(c); cfg_t = 1'(t); cfg_n = 5'(f);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    while (n <= done_c + 1) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    chk("R10", "outputs in reset",
        int'({excite, svalid, wr_en, judge, done, ovr} != 0 || wr_data != 0), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pat = 0; start_cycle(3, 4, 8, 0, 1); wait_idle();
    pat = 0; start_cycle(2, 1, 10, 1, 4); wait_idle();
    pat = 2; start_cycle(1, 2, 9, 1, 3); wait_idle();
    pat = 1; start_cycle(1, 0, 6, 1, 2); wait_idle();
    pat = 0; start_cycle(0, 0, 0, 0, 0); wait_idle();
    pat = 0; start_cycle(2, 3, 5, 1, 0); wait_idle();
    pat = 0; start_cycle(1, 1, 20, 1, 31); wait_idle();
    pat = 2; start_cycle(1, 1, 7, 1, 16); wait_idle();

    // R9: setup changed mid-cycle must not alter the running cycle
    pat = 0;
    base = wr_seen;
    start_cycle(2, 2, 6, 0, 1);
    cfg_c = 16'd40; cfg_t = 1'b1; cfg_n = 5'd5; cfg_w = 16'd9;
    wait_idle();
    chk("R9", "writes after mid-cycle setup change", wr_seen - base, 6);

    // R8: a second edge during excitation is dropped and flagged
    start_cycle(5, 5, 5, 0, 1);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    wait_idle();
    chk("R8", "overrun after busy edge", int'(ovr), 1);

    // Next cycle still runs normally with overrun held
    start_cycle(2, 0, 4, 1, 2); wait_idle();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule